// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a processor reach registers that sit in a slow, always-on peripheral domain without mapping them directly. The processor sees four local 32-bit registers on a simple synchronous register port. It loads a target address, a write word and a byte-enable code, then starts one far-side transfer by writing to a control register. While the transfer runs it polls that same register.

On the far side the bridge raises a request. The request carries the address, the write word, the byte-enable code and a write indication, all held steady until the far domain acknowledges. A byte-enable code of zero makes the transfer a read, and the returned word is latched into the local data register. Any other code makes it a write, and the data register keeps the word that software stored. Only one transfer is in flight at a time. Register writes that arrive during a transfer are discarded, so a transfer in progress cannot be corrupted.

Top module: `ind_reg_bridge`

## Requirements
- R1: Byte offsets decode as follows: 0x0 is control, 0x4 is byte-enable, 0x8 is target address and 0xC is the data word. A read strobe returns the selected register on cpu_rdata_o in the cycle after the strobe. The byte-enable register stores write-data bits 7:0, and its bits 31:8 read as zero.
- R2: A write of exactly 1 to control while idle starts a transfer, and far_req_o rises in the next cycle. Writing any other value to control starts nothing.
- R3: Control reads 1 from the cycle after the start write up to and including the cycle in which far_ack_i is sampled high. It reads 0 at all other times.
- R4: A byte-enable register value of 0x00 makes the transfer a read (far_we_o low). The data register takes far_rdata_i on the edge where the acknowledge is sampled.
- R5: A nonzero byte-enable value makes the transfer a write (far_we_o high). far_be_o carries the 8-bit code unchanged, and the data register keeps the software-written word after the acknowledge.
- R6: far_addr_o, far_wdata_o, far_be_o and far_we_o hold steady while far_req_o is high. far_req_o stays high until far_ack_i is sampled and drops in the next cycle.
- R7: While a transfer is in flight, writes to all four registers are ignored.
- R8: Asynchronous reset clears all four registers and cpu_rdata_o to zero, and leaves the block idle with far_req_o low.
- R9: An access whose address bits 1:0 are nonzero is ignored. A write to such an address changes nothing, and a read from it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 4 | Register byte offset |
| cpu_wr_i | input | 1 | Write strobe |
| cpu_rd_i | input | 1 | Read strobe |
| cpu_wdata_i | input | 32 | Write data |
| cpu_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| far_req_o | output | 1 | Far-side transfer request |
| far_we_o | output | 1 | Far-side write indication |
| far_addr_o | output | 32 | Far-side target address |
| far_wdata_o | output | 32 | Far-side write word |
| far_be_o | output | 8 | Far-side byte-enable code |
| far_ack_i | input | 1 | Far-side acknowledge |
| far_rdata_i | input | 32 | Far-side read data, valid with the acknowledge |

## Verification
Transfers are run with both a zero code (read) and several nonzero codes (write), against a responder that answers after 1 to 16 cycles. This separates a bridge that decodes direction correctly from one that only tests a single bit, and it exposes busy timing that depends on a fixed delay. Writes issued while busy, control values other than 1, and misaligned offsets each tell an ignored access apart from a leaking one. The outcome of each is read back through the registers or watched on the far-side port.

// File: rtl/iob_pkg.sv
package iob_pkg;
  localparam int DW   = 32;
  localparam int BE_W = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BE   = 2'd1,
    SEL_ADDR = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/iob_far_seq.sv
module iob_far_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_i,
  output logic busy_o,
  output logic done_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                busy_q <= 1'b0;
    else if (start_i && !busy_q) busy_q <= 1'b1;
    else if (ack_i && busy_q)   busy_q <= 1'b0;
  end

  assign busy_o = busy_q;
  assign done_o = busy_q & ack_i;
endmodule

// File: rtl/iob_regs.sv
module iob_regs
  import iob_pkg::*;
#(
  parameter int DW_P = DW,
  parameter int BE_P = BE_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  reg_sel_e        wr_sel_i,
  input  logic [DW_P-1:0] wdata_i,
  input  logic            cap_i,
  input  logic [DW_P-1:0] cap_data_i,
  input  logic            rd_en_i,
  input  logic            rd_ok_i,
  input  reg_sel_e        rd_sel_i,
  input  logic            busy_i,
  output logic [BE_P-1:0] be_o,
  output logic [DW_P-1:0] addr_o,
  output logic [DW_P-1:0] data_o,
  output logic [DW_P-1:0] rdata_o
);
  localparam int PAD_W = DW_P - BE_P;

  logic [BE_P-1:0] be_q;
  logic [DW_P-1:0] addr_q, data_q, rdata_q, rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      be_q   <= '0;
      addr_q <= '0;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_BE)   be_q   <= wdata_i[BE_P-1:0];
      if (wr_sel_i == SEL_ADDR) addr_q <= wdata_i;
    end
  end

  // far-side capture and software write never coincide: writes are gated by busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                data_q <= '0;
    else if (cap_i)                             data_q <= cap_data_i;
    else if (wr_en_i && wr_sel_i == SEL_DATA)   data_q <= wdata_i;
  end

  always_comb begin
    unique case (rd_sel_i)
      SEL_CTRL: rd_mux = {{(DW_P-1){1'b0}}, busy_i};
      SEL_BE:   rd_mux = {{PAD_W{1'b0}}, be_q};
      SEL_ADDR: rd_mux = addr_q;
      default:  rd_mux = data_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_ok_i ? rd_mux : '0;
  end

  assign be_o    = be_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import iob_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   cpu_addr_i,
  input  logic            cpu_wr_i,
  input  logic            cpu_rd_i,
  input  logic [DW-1:0]   cpu_wdata_i,
  output logic [DW-1:0]   cpu_rdata_o,
  output logic            far_req_o,
  output logic            far_we_o,
  output logic [DW-1:0]   far_addr_o,
  output logic [DW-1:0]   far_wdata_o,
  output logic [BE_W-1:0] far_be_o,
  input  logic            far_ack_i,
  input  logic [DW-1:0]   far_rdata_i
);
  localparam logic [DW-1:0] GO_VAL = DW'(1);

  logic            aligned, busy, done, wr_en, start, cap;
  reg_sel_e        sel;
  logic [BE_W-1:0] be_w;
  logic [DW-1:0]   data_w;

  assign aligned = (cpu_addr_i[1:0] == 2'b00);
  assign sel     = reg_sel_e'(cpu_addr_i[3:2]);
  assign wr_en   = cpu_wr_i & aligned & ~busy;
  assign start   = wr_en & (sel == SEL_CTRL) & (cpu_wdata_i == GO_VAL);
  assign cap     = done & (be_w == '0);

  iob_far_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .ack_i   (far_ack_i),
    .busy_o  (busy),
    .done_o  (done)
  );

  iob_regs #(.DW_P(DW), .BE_P(BE_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_sel_i   (sel),
    .wdata_i    (cpu_wdata_i),
    .cap_i      (cap),
    .cap_data_i (far_rdata_i),
    .rd_en_i    (cpu_rd_i),
    .rd_ok_i    (aligned),
    .rd_sel_i   (sel),
    .busy_i     (busy),
    .be_o       (be_w),
    .addr_o     (far_addr_o),
    .data_o     (data_w),
    .rdata_o    (cpu_rdata_o)
  );

  assign far_req_o   = busy;
  assign far_we_o    = |be_w;
  assign far_be_o    = be_w;
  assign far_wdata_o = data_w;
endmodule

// File: rtl/iob_bridge_chk.sv
module iob_bridge_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  cpu_addr_i,
  input logic        cpu_wr_i,
  input logic [31:0] cpu_wdata_i,
  input logic        far_req_o,
  input logic        far_we_o,
  input logic [31:0] far_addr_o,
  input logic [31:0] far_wdata_o,
  input logic [7:0]  far_be_o,
  input logic        far_ack_i,
  input logic [31:0] far_rdata_i,
  input logic [31:0] data_q
);
  logic go_wr;
  assign go_wr = cpu_wr_i && cpu_addr_i == 4'h0 && cpu_wdata_i == 32'd1;

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !far_req_o && go_wr |=> far_req_o);
  assert_no_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !far_req_o && !go_wr |=> !far_req_o);
  assert_rd_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    far_req_o && far_ack_i && !far_we_o |=> data_q == $past(far_rdata_i));
  assert_wr_keeps_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    far_req_o && far_ack_i && far_we_o |=> $stable(data_q));
  assert_req_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    far_req_o && !far_ack_i |=> far_req_o && $stable(far_addr_o) && $stable(far_wdata_o)
                                && $stable(far_be_o) && $stable(far_we_o));
  assert_req_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    far_req_o && far_ack_i |=> !far_req_o);
  assert_busy_addr_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    far_req_o && cpu_wr_i |=> $stable(far_addr_o) && $stable(far_be_o));
endmodule

bind ind_reg_bridge iob_bridge_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_wr_i    (cpu_wr_i),
  .cpu_wdata_i (cpu_wdata_i),
  .far_req_o   (far_req_o),
  .far_we_o    (far_we_o),
  .far_addr_o  (far_addr_o),
  .far_wdata_o (far_wdata_o),
  .far_be_o    (far_be_o),
  .far_ack_i   (far_ack_i),
  .far_rdata_i (far_rdata_i),
  .data_q      (data_w)
);

// File: tb/tb_ind_reg_bridge.sv
module tb_ind_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req, we;
  logic [31:0] far_addr, far_wdata;
  logic [7:0]  far_be;
  logic        ack = 1'b0;
  logic [31:0] far_rdata = '0;

  always #10 clk = ~clk;

  ind_reg_bridge dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_wr_i(wr), .cpu_rd_i(rd),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .far_req_o(req), .far_we_o(we),
    .far_addr_o(far_addr), .far_wdata_o(far_wdata), .far_be_o(far_be),
    .far_ack_i(ack), .far_rdata_i(far_rdata)
  );

  int checks = 0, fails = 0;
  string cur_tag = "R1";

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%08h exp=0x%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference array in the far domain
  logic [31:0] mem [16];
  initial for (int i = 0; i < 16; i++) mem[i] = 32'hA500_0000 + i * 32'h0101_0101;

  // responder: ack after 1..16 cycles
  int dly = -1;
  always @(negedge clk) begin
    if (ack) begin
      ack = 1'b0;
      dly = -1;
    end else if (req) begin
      if (dly < 0) dly = $urandom_range(1, 16);
      dly--;
      if (dly == 0) begin
        ack = 1'b1;
        far_rdata = mem[far_addr[5:2]];
      end
    end
  end
  always @(posedge clk) if (rst_n && ack && we) mem[far_addr[5:2]] = far_wdata;

  // reference model and scoreboard
  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t q[$];
  bit   pend = 0;
  logic        m_busy;
  logic [7:0]  m_be;
  logic [31:0] m_addr, m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_be = '0; m_addr = '0; m_data = '0;
    end else begin
      logic b_old;
      b_old = m_busy;
      if (rd) begin
        exp_t e;
        e.tag = (addr == 4'h0) ? "R3" : cur_tag;
        if (addr[1:0] != 2'b00) e.exp = '0;
        else case (addr[3:2])
          2'd0: e.exp = {31'd0, m_busy};
          2'd1: e.exp = {24'd0, m_be};
          2'd2: e.exp = m_addr;
          default: e.exp = m_data;
        endcase
        q.push_back(e);
        pend = 1;
      end
      if (b_old && ack) begin
        m_busy = 0;
        if (m_be == 8'h00) m_data = mem[m_addr[5:2]];
      end
      if (wr && !b_old && addr[1:0] == 2'b00) case (addr[3:2])
        2'd0: if (wdata == 32'd1) m_busy = 1;
        2'd1: m_be = wdata[7:0];
        2'd2: m_addr = wdata;
        default: m_data = wdata;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check(req == 1'b0, "R8 req in reset", {31'd0, req}, 32'd0);
      check(rdata == '0, "R8 rdata in reset", rdata, 32'd0);
    end else begin
      if (pend) begin
        exp_t e;
        e = q.pop_front();
        pend = 0;
        check(rdata === e.exp, e.tag, rdata, e.exp);
      end
      check(req === m_busy, "R2 R3 far_req_o", {31'd0, req}, {31'd0, m_busy});
      if (m_busy) begin
        check(far_addr === m_addr, "R6 far_addr_o", far_addr, m_addr);
        check(far_wdata === m_data, "R6 far_wdata_o", far_wdata, m_data);
        check(far_be === m_be, "R5 far_be_o", {24'd0, far_be}, {24'd0, m_be});
        check(we === (m_be != 0), "R4 R5 far_we_o", {31'd0, we}, {31'd0, m_be != 0});
      end
    end
  end

  task automatic cpu_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [3:0] a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    #1;
  endtask

  task automatic poll();
    int n = 0;
    do begin
      cpu_rd(4'h0);
      n++;
    end while (rdata != 0 && n < 40);
    check(n < 40, "R3 completion", n, 40);
  endtask

  task automatic xfer(input logic [7:0] be, input logic [31:0] a, input logic [31:0] d);
    poll();
    cpu_wr(4'h4, {24'hFFFFFF, be});
    cpu_wr(4'h8, a);
    cpu_wr(4'hC, d);
    cpu_wr(4'h0, 32'd1);
    poll();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    // R8: reset values
    cur_tag = "R8";
    cpu_rd(4'h0); cpu_rd(4'h4); cpu_rd(4'h8); cpu_rd(4'hC);
    // R1: decode and byte-enable width
    cur_tag = "R1";
    cpu_wr(4'h4, 32'hFFFF_FFAB); cpu_rd(4'h4);
    cpu_wr(4'h8, 32'h0000_0014); cpu_rd(4'h8);
    cpu_wr(4'hC, 32'h1234_5678); cpu_rd(4'hC);
    // R9: misaligned ignored
    cur_tag = "R9";
    cpu_wr(4'h9, 32'hDEAD_BEEF); cpu_rd(4'h8);
    cpu_rd(4'hA);
    cpu_wr(4'h1, 32'd1); cpu_rd(4'h0);
    // R2: control values other than 1
    cur_tag = "R2";
    cpu_wr(4'h0, 32'd2); cpu_rd(4'h0);
    cpu_wr(4'h0, 32'h8000_0001); cpu_rd(4'h0);
    // R5 and R7: write transfer with writes during busy
    cur_tag = "R5";
    poll();
    cpu_wr(4'h4, 32'h0000_00F1);
    cpu_wr(4'h8, 32'h0000_0008);
    cpu_wr(4'hC, 32'hCAFE_0001);
    cpu_wr(4'h0, 32'd1);
    cur_tag = "R7";
    cpu_wr(4'h8, 32'h0000_0030);
    cpu_wr(4'hC, 32'h5555_5555);
    cpu_wr(4'h4, 32'h0000_0000);
    cpu_wr(4'h0, 32'd1);
    poll();
    cpu_rd(4'h8); cpu_rd(4'h4);
    cur_tag = "R5";
    cpu_rd(4'hC);
    // R4: read back the written word and another entry
    cur_tag = "R4";
    xfer(8'h00, 32'h0000_0008, 32'h0);
    cpu_rd(4'hC);
    xfer(8'h00, 32'h0000_003C, 32'h0);
    cpu_rd(4'hC);
    // mixed random traffic
    for (int i = 0; i < 40; i++) begin
      logic [7:0] be;
      be = (i % 2 == 0) ? 8'h00 : 8'($urandom_range(1, 255));
      cur_tag = (be == 0) ? "R4" : "R5";
      xfer(be, {26'd0, 4'($urandom_range(0, 15)), 2'b00}, $urandom);
      cpu_rd(4'hC);
    end
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog act=0x%08h exp=0x%08h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule